// File: doc/BRIEF.md
# ADC Output Format Converter

This block sits on the capture side of a pipelined converter with a 13-bit parallel data bus and an out-of-range flag. It registers each raw word and turns it into a signed, two's-complement sample sign-extended to a 16-bit output. It also raises an overflow flag with the same one-cycle latency. A format input tells the block whether the converter is set to emit offset binary or two's complement. A mode input selects one of three readings of the bus: the full 13-bit word, a 12-bit word with the least significant bit discarded, or a reduced-range 12-bit word.

In the reduced-range reading the converter's low twelve bits wrap around when the input passes full scale. The block therefore watches the two uppermost raw bits. When they show that the signal left the range, it replaces the wrapped code with the positive or negative 12-bit limit and raises the overflow flag. In the other two readings the converter's own out-of-range flag is passed through as the overflow flag.

Mode and format are taken into an internal configuration register only on cycles where the data-valid input is low. A stream is therefore always decoded with one fixed setting. When no valid word arrives, the output sample and the overflow flag keep their last values.

Top module: `adc_fmt_conv`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `out_valid`, `out_sample` and `out_ovf` are all zero. The configuration returns to full mode with offset binary.
- R2: `out_valid` equals the `in_valid` of the previous cycle. Every result appears exactly one cycle after its raw word is presented.
- R3: Mode codes: 0 = full, 1 = 12-bit trim, 2 = reduced range, 3 = same as full. In full mode with `fmt_twos`=0 the sample is the raw code minus 4096, so mid-scale 4096 gives 0. With `fmt_twos`=1 the raw code is read as a 13-bit two's-complement number.
- R4: In trim mode the sample is the signed value of raw bits 12 down to 1, which is the full-mode value shifted right arithmetically by one. Raw bit 0 has no effect.
- R5: In full and trim modes `out_ovf` equals the `raw_oor` input that came with the word.
- R6: In reduced-range mode, a word that is in range gives a sample equal to raw bits 11 down to 0 read as a 12-bit two's-complement value, for either format, with `out_ovf` low.
- R7: In reduced-range mode with offset binary, raw bits 12 and 11 both 1 mean over-range and the sample becomes +2047. Both 0 mean under-range and the sample becomes -2048. In both cases `out_ovf` is high.
- R8: In reduced-range mode with two's complement, raw bit 12 = 0 and bit 11 = 1 mean over-range (+2047). Bit 12 = 1 and bit 11 = 0 mean under-range (-2048). In both cases `out_ovf` is high.
- R9: `mode_sel` and `fmt_twos` are taken in only on cycles with `in_valid` low. A change while `in_valid` is high has no effect on the decode.
- R10: On a cycle after `in_valid` was low, `out_sample` and `out_ovf` keep their previous values.
- R11: Output bits 15 down to 12 always equal bit 12, so the sample is a sign-extended 13-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Raw word valid this cycle |
| raw_code | input | 13 | Parallel word from the converter |
| raw_oor | input | 1 | Converter out-of-range flag |
| mode_sel | input | 2 | Reading of the bus: 0 full, 1 trim, 2 reduced range, 3 full |
| fmt_twos | input | 1 | Converter format: 0 offset binary, 1 two's complement |
| out_valid | output | 1 | Sample valid |
| out_sample | output | 16 | Signed sample, two's complement, sign-extended |
| out_ovf | output | 1 | Overflow / clamp flag |

## Verification
Two things can meet in the same cycle: a decode of a valid word and a request on `mode_sel`/`fmt_twos` to switch the decoding. The bench provokes this by switching to reduced-range two's complement in the middle of a full-mode offset-binary stream, on a word whose two readings differ (8191 gives 4095 in one and -1 in the other). The result must still follow the old setting. After one idle cycle, during which the held output is also checked, the same word must decode under the new setting. Around this, every raw code is swept under every mode and format, and each output is compared with values computed arithmetically.

// File: rtl/adc_fmt_pkg.sv
`timescale 1ns/1ps
package adc_fmt_pkg;

    localparam int RAW_W  = 13;
    localparam int HALF_W = RAW_W - 1;

    typedef enum logic [1:0] {
        MODE_FULL = 2'd0,
        MODE_TRIM = 2'd1,
        MODE_HALF = 2'd2,
        MODE_ALT  = 2'd3
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  twos;
    } cfg_t;

    typedef struct packed {
        logic [RAW_W-1:0] val;
        logic             ovf;
    } res_t;

    // Offset binary and two's complement differ only in the top bit.
    function automatic logic [RAW_W-1:0] to_signed_code(input logic [RAW_W-1:0] raw,
                                                         input logic twos);
        return twos ? raw : {~raw[RAW_W-1], raw[RAW_W-2:0]};
    endfunction

    // Bring the top two raw bits into offset-binary meaning.
    function automatic logic [1:0] top_as_offset(input logic [1:0] top,
                                                 input logic twos);
        return {top[1] ^ twos, top[0]};
    endfunction

endpackage

// File: rtl/adc_fmt_cfg.sv
`timescale 1ns/1ps
module adc_fmt_cfg
    import adc_fmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [1:0] mode_sel,
    input  logic       fmt_twos,
    output cfg_t       cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.mode <= MODE_FULL;
            cfg.twos <= 1'b0;
        end else if (!in_valid) begin
            cfg.mode <= mode_e'(mode_sel);
            cfg.twos <= fmt_twos;
        end
    end

endmodule

// File: rtl/adc_fmt_clamp.sv
`timescale 1ns/1ps
module adc_fmt_clamp
    import adc_fmt_pkg::*;
#(
    parameter int W = HALF_W
) (
    input  logic [1:0]   top_bits,
    input  logic [W-1:0] low_bits,
    input  logic         twos,
    output logic [W-1:0] val,
    output logic         ovf
);

    localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

    logic [1:0] top_ob;
    logic       over;
    logic       under;

    assign top_ob = top_as_offset(top_bits, twos);
    assign over   = &top_ob;
    assign under  = ~|top_ob;

    always_comb begin
        if (over)       val = POS_LIM;
        else if (under) val = NEG_LIM;
        else            val = low_bits;
        ovf = over | under;
    end

endmodule

// File: rtl/adc_fmt_decode.sv
`timescale 1ns/1ps
module adc_fmt_decode
    import adc_fmt_pkg::*;
(
    input  logic [RAW_W-1:0] raw,
    input  logic             oor,
    input  cfg_t             cfg,
    output res_t             res
);

    logic [RAW_W-1:0]  sc;
    logic [RAW_W-1:0]  trimmed;
    logic [HALF_W-1:0] half_val;
    logic              half_ovf;

    assign sc      = to_signed_code(raw, cfg.twos);
    assign trimmed = {sc[RAW_W-1], sc[RAW_W-1:1]};

    adc_fmt_clamp #(.W(HALF_W)) u_clamp (
        .top_bits (raw[RAW_W-1 -: 2]),
        .low_bits (raw[HALF_W-1:0]),
        .twos     (cfg.twos),
        .val      (half_val),
        .ovf      (half_ovf)
    );

    always_comb begin
        unique case (cfg.mode)
            MODE_TRIM: begin
                res.val = trimmed;
                res.ovf = oor;
            end
            MODE_HALF: begin
                res.val = {half_val[HALF_W-1], half_val};
                res.ovf = half_ovf;
            end
            default: begin
                res.val = sc;
                res.ovf = oor;
            end
        endcase
    end

endmodule

// File: rtl/adc_fmt_conv.sv
`timescale 1ns/1ps
module adc_fmt_conv
    import adc_fmt_pkg::*;
#(
    parameter int OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [12:0]      raw_code,
    input  logic             raw_oor,
    input  logic [1:0]       mode_sel,
    input  logic             fmt_twos,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_sample,
    output logic             out_ovf
);

    localparam int EXT_W = OUT_W - RAW_W;

    cfg_t             cfg_q;
    res_t             res;
    logic [OUT_W-1:0] ext;

    adc_fmt_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .mode_sel (mode_sel),
        .fmt_twos (fmt_twos),
        .cfg      (cfg_q)
    );

    adc_fmt_decode u_dec (
        .raw (raw_code),
        .oor (raw_oor),
        .cfg (cfg_q),
        .res (res)
    );

    generate
        if (EXT_W > 0) begin : g_ext
            assign ext = {{EXT_W{res.val[RAW_W-1]}}, res.val};
        end else begin : g_noext
            assign ext = res.val[OUT_W-1:0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
            out_ovf    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_sample <= ext;
                out_ovf    <= res.ovf;
            end
        end
    end

endmodule

// File: rtl/adc_fmt_conv_chk.sv
`timescale 1ns/1ps
module adc_fmt_conv_chk #(
    parameter int OUT_W = 16,
    parameter int RAW_W = 13
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             raw_oor,
    input logic [1:0]       cur_mode,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_sample,
    input logic             out_ovf
);

    localparam int SX_W = OUT_W - RAW_W + 1;
    localparam int HX_W = OUT_W - RAW_W + 2;
    localparam logic [OUT_W-1:0] HPOS = OUT_W'((1 << (RAW_W - 2)) - 1);
    localparam logic [OUT_W-1:0] HNEG = ~HPOS;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && out_sample == '0 && !out_ovf));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R5
    oor_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cur_mode != 2'd2) |=> (out_ovf == $past(raw_oor)));

    // R7
    half_clamp_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cur_mode == 2'd2) |=>
            (!out_ovf || out_sample == HPOS || out_sample == HNEG));

    // R6
    half_range_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cur_mode == 2'd2) |=>
            ($countones(out_sample[OUT_W-1:RAW_W-2]) == 0 ||
             $countones(out_sample[OUT_W-1:RAW_W-2]) == HX_W));

    // R9
    cfg_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> $stable(cur_mode));

    // R10
    hold_out_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_sample) && $stable(out_ovf)));

    // R11
    sign_ext_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(out_sample[OUT_W-1:RAW_W-1]) == 0 ||
         $countones(out_sample[OUT_W-1:RAW_W-1]) == SX_W));

endmodule

bind adc_fmt_conv adc_fmt_conv_chk #(
    .OUT_W (OUT_W),
    .RAW_W (adc_fmt_pkg::RAW_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .raw_oor    (raw_oor),
    .cur_mode   (cfg_q.mode),
    .out_valid  (out_valid),
    .out_sample (out_sample),
    .out_ovf    (out_ovf)
);

// File: tb/tb_adc_fmt_conv.sv
`timescale 1ns/1ps
module tb_adc_fmt_conv;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [12:0] raw_code = '0;
    logic        raw_oor = 1'b0;
    logic [1:0]  mode_sel = '0;
    logic        fmt_twos = 1'b0;
    logic        out_valid;
    logic [15:0] out_sample;
    logic        out_ovf;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_mode = 0;
    int m_twos = 0;
    int held_v = 0;
    bit held_f = 0;

    always #10 clk = ~clk;

    adc_fmt_conv dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .raw_code(raw_code),
        .raw_oor(raw_oor), .mode_sel(mode_sel), .fmt_twos(fmt_twos),
        .out_valid(out_valid), .out_sample(out_sample), .out_ovf(out_ovf)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic void model(input int raw, input int mode, input int tw,
                                  input bit oor, output int v, output bit f);
        int full_v;
        int top;
        int low;
        full_v = tw ? (raw >= 4096 ? raw - 8192 : raw) : raw - 4096;
        f = oor;
        if (mode == 1) begin
            v = full_v >>> 1;
        end else if (mode == 2) begin
            top = raw >> 11;
            low = raw & 4095;
            v = (low >= 2048) ? low - 4096 : low;
            f = 0;
            if ((tw && top == 1) || (!tw && top == 3)) begin
                v = 2047; f = 1;
            end else if ((tw && top == 2) || (!tw && top == 0)) begin
                v = -2048; f = 1;
            end
        end else begin
            v = full_v;
        end
    endfunction

    function automatic string req_of(input int mode, input int tw, input int raw);
        int top;
        top = raw >> 11;
        if (mode == 1) return "R4";
        if (mode == 2) begin
            if (tw && (top == 1 || top == 2)) return "R8";
            if (!tw && (top == 0 || top == 3)) return "R7";
            return "R6";
        end
        return "R3";
    endfunction

    task automatic step(input bit vld, input int raw, input bit oor,
                        input int mode, input int tw);
        int ev;
        bit ef;
        int act;
        string rq;
        in_valid = vld;
        raw_code = 13'(raw);
        raw_oor  = oor;
        mode_sel = 2'(mode);
        fmt_twos = tw[0];
        model(raw, m_mode, m_twos, oor, ev, ef);
        rq = req_of(m_mode, m_twos, raw);
        if (!vld) begin
            m_mode = mode;
            m_twos = tw;
        end
        @(posedge clk);
        @(negedge clk);
        chk(out_valid == vld, "R2", int'(out_valid), int'(vld));
        act = $signed(out_sample);
        if (vld) begin
            chk(act == ev, rq, act, ev);
            chk(out_ovf == ef, (m_mode == 2) ? rq : "R5", int'(out_ovf), int'(ef));
            chk(out_sample[15:12] == {4{out_sample[12]}}, "R11", int'(out_sample[15:12]), 0);
            held_v = ev;
            held_f = ef;
        end else begin
            chk(act == held_v, "R10", act, held_v);
            chk(out_ovf == held_f, "R10", int'(out_ovf), int'(held_f));
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs clear while reset is held
        chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
        chk(out_sample == '0, "R1", int'(out_sample), 0);
        chk(out_ovf == 1'b0, "R1", int'(out_ovf), 0);
        rst = 1'b0;

        // R1: default configuration is full mode offset binary (4096 -> 0)
        step(1, 4096, 0, 2, 1);
        step(1, 8191, 0, 1, 1);

        // Exhaustive sweep of every raw code under every mode and format
        for (int tw = 0; tw < 2; tw++) begin
            for (int md = 0; md < 4; md++) begin
                step(0, 0, 0, md, tw);
                for (int raw = 0; raw < 8192; raw++) begin
                    step(1, raw, bit'(((raw >> 3) ^ (raw >> 9)) & 1), md, tw);
                end
            end
        end

        // R4: bit 0 has no effect in trim mode
        step(0, 0, 0, 1, 0);
        step(1, 5000, 0, 0, 0);
        step(1, 5001, 0, 0, 0);

        // R9: a config change during a stream is ignored
        step(0, 0, 0, 0, 0);
        step(1, 4096, 0, 0, 0);
        step(1, 8191, 0, 2, 1);
        chk($signed(out_sample) == 4095, "R9", int'($signed(out_sample)), 4095);
        // R10: idle cycle holds the previous sample, config taken in now
        step(0, 123, 1, 2, 1);
        step(1, 8191, 0, 0, 0);
        chk($signed(out_sample) == -1, "R9", int'($signed(out_sample)), -1);

        // R1: reset again mid-run
        rst = 1'b1;
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0 && out_sample == '0, "R1", int'(out_sample), 0);
        rst = 1'b0;
        m_mode = 0; m_twos = 0; held_v = 0; held_f = 0;
        step(1, 0, 1, 2, 1);

        done = 1;
        finish_run();
    end

endmodule